// File: doc/BRIEF.md
# I2C-Mode Receive Shifter with Acknowledge Detection

This block is the receive half of a serial channel working as an I2C device. It synchronizes an externally supplied SCL and SDA into the system clock domain and finds SCL rising and falling edges there. On each rising edge it captures one SDA bit. A frame is nine clocks long: eight data bits followed by one acknowledge bit. The captured frame goes into a 9-bit receive buffer. A layout-select input decides where the data bits and the acknowledge bit land in that buffer. In the alternate layout, a clock-delay input makes the buffer switch back to the normal layout once the ninth clock has risen.

In the normal layout, the acknowledge bit produces either an ACK event or a NACK event. Each event is a one-cycle pulse, and an ACK can also raise a one-cycle DMA request. When the block is set up to answer a transfer, it pulls SDA low during the ninth clock if the programmed acknowledge value is 0. The pins are open-drain: the block either drives low or releases the line. Configuration arrives as static input bits. Start/stop generation, bit-rate generation and arbitration sit outside this block.

Top module: `i2crx_top`

## Requirements
- R1: After reset `rx_buf` is 0, `rx_done`, `ack_evt`, `nack_evt`, `dma_req` and `sda_oe` are 0, `sda_o` is 1, and the first SCL rising edge captures frame bit 1.
- R2: With `cfg_layout_alt`=0, at the ninth rising SCL edge `rx_buf[7:0]` takes received bits 1..8, with bit 1 in position 7, and `rx_buf[8]` takes received bit 9.
- R3: With `cfg_layout_alt`=1, at the eighth rising SCL edge `rx_buf[6:0]` takes received bits 1..7 (bit 1 in position 6), `rx_buf[8]` takes received bit 8 and `rx_buf[7]` is 0. With `cfg_clk_delay`=0 this content is kept through the ninth rising edge.
- R4: With `cfg_layout_alt`=1 and `cfg_clk_delay`=1, the ninth rising SCL edge replaces `rx_buf` with the R2 layout of the same frame.
- R5: With `cfg_layout_alt`=0, the ninth rising SCL edge raises `ack_evt` if SDA is 0 and `nack_evt` if SDA is 1. Each is a single-cycle pulse in the same cycle as `rx_done`. With `cfg_layout_alt`=1, neither event is raised.
- R6: `dma_req` pulses for one cycle together with `ack_evt` when `cfg_dma_on_ack`=1. It stays 0 otherwise.
- R7: `rx_done` pulses for one cycle on every ninth rising SCL edge. The bit counter then wraps to 1, so back-to-back frames are received without any other event.
- R8: With `cfg_ss_out_en`=0, `cfg_ack_out_en`=1 and `cfg_ack_val`=0, `sda_oe`=1 and `sda_o`=0 from the SCL falling edge after bit 8 until the SCL falling edge after bit 9. In every other case, and outside that window, `sda_oe`=0 and `sda_o`=1.
- R9: The registered outputs respond SYNC_STAGES+1 system clocks after an SCL edge changes at the pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | SCL line level, asynchronous |
| sda_in | input | 1 | SDA line level, asynchronous |
| cfg_layout_alt | input | 1 | 1 selects the alternate buffer layout |
| cfg_clk_delay | input | 1 | 1 restores the normal layout after the ninth clock |
| cfg_ss_out_en | input | 1 | 1 when start/stop output owns SDA; blocks acknowledge drive |
| cfg_ack_out_en | input | 1 | 1 enables acknowledge output |
| cfg_ack_val | input | 1 | Acknowledge value to send (0 = ACK) |
| cfg_dma_on_ack | input | 1 | 1 makes an ACK raise a DMA request |
| rx_buf | output | 9 | Receive buffer |
| rx_done | output | 1 | One-cycle frame-complete pulse |
| ack_evt | output | 1 | One-cycle ACK detected pulse |
| nack_evt | output | 1 | One-cycle NACK detected pulse |
| dma_req | output | 1 | One-cycle DMA request |
| sda_oe | output | 1 | 1 while SDA is pulled low |
| sda_o | output | 1 | Requested SDA level (0 when driving, 1 when released) |

## Verification
The bench builds the block with SYNC_STAGES set to 3 rather than the default 2. This shows that the frame logic and the acknowledge window depend only on the detected edges and not on a fixed synchronizer depth. It also makes the latency check of R9 track a non-default value. SCL is held steady for six system clocks per phase. That is long enough for the deeper synchronizer to settle, so the acknowledge drive and the intermediate alternate-layout buffer can each be observed inside a single SCL phase.

// File: rtl/i2crx_pkg.sv
package i2crx_pkg;

    localparam int FRAME_LEN = 9;
    localparam int BUF_W     = 9;
    localparam int DATA_LEN  = FRAME_LEN - 1;
    localparam int CNT_W     = $clog2(FRAME_LEN + 1);

    typedef logic [CNT_W-1:0] bitpos_t;
    typedef logic [BUF_W-1:0] rxbuf_t;

    typedef struct packed {
        logic layout_alt;
        logic clk_delay;
        logic ss_out_en;
        logic ack_out_en;
        logic ack_val;
        logic dma_on_ack;
    } rx_cfg_t;

    typedef struct packed {
        logic rise;
        logic fall;
        logic level;
        logic sda;
    } line_evt_t;

    typedef struct packed {
        rxbuf_t data;
        logic   done;
        logic   ack;
        logic   nack;
        logic   dma;
    } rx_result_t;

    // seq[8] is the first bit on the wire, seq[0] the acknowledge bit
    function automatic rxbuf_t layout_normal(input logic [FRAME_LEN-1:0] seq);
        return {seq[0], seq[FRAME_LEN-1:1]};
    endfunction

    // first8[7] is the first bit on the wire, first8[0] the eighth
    function automatic rxbuf_t layout_alt(input logic [DATA_LEN-1:0] first8);
        return {first8[0], 1'b0, first8[DATA_LEN-1:1]};
    endfunction

endpackage

// File: rtl/i2crx_sync.sv
module i2crx_sync #(
    parameter int STAGES = 2,
    parameter int WIDTH  = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] d_sync
);
    genvar g;
    generate
        for (g = 0; g < WIDTH; g++) begin : g_line
            logic [STAGES-1:0] chain;
            always_ff @(posedge clk) begin
                if (rst) chain <= '1;
                else     chain <= {chain[STAGES-2:0], d_async[g]};
            end
            assign d_sync[g] = chain[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/i2crx_edge.sv
module i2crx_edge
    import i2crx_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      scl_s,
    input  logic      sda_s,
    output line_evt_t evt
);
    logic scl_prev;

    always_ff @(posedge clk) begin
        if (rst) scl_prev <= 1'b1;
        else     scl_prev <= scl_s;
    end

    always_comb begin
        evt.rise  = scl_s & ~scl_prev;
        evt.fall  = ~scl_s & scl_prev;
        evt.level = scl_s;
        evt.sda   = sda_s;
    end
endmodule

// File: rtl/i2crx_frame.sv
module i2crx_frame
    import i2crx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  line_evt_t  evt,
    input  rx_cfg_t    cfg,
    output rx_result_t res,
    output logic       ack_win
);
    bitpos_t             cnt;
    logic [DATA_LEN-1:0] sreg;
    rxbuf_t              buf_q;
    logic                done_q, ack_q, nack_q, dma_q;

    logic last_bit, data_end;
    assign last_bit = (cnt == bitpos_t'(FRAME_LEN));
    assign data_end = (cnt == bitpos_t'(DATA_LEN));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= bitpos_t'(1);
            sreg    <= '0;
            buf_q   <= '0;
            done_q  <= 1'b0;
            ack_q   <= 1'b0;
            nack_q  <= 1'b0;
            dma_q   <= 1'b0;
            ack_win <= 1'b0;
        end else begin
            done_q <= 1'b0;
            ack_q  <= 1'b0;
            nack_q <= 1'b0;
            dma_q  <= 1'b0;
            if (evt.fall)
                ack_win <= last_bit;
            if (evt.rise) begin
                sreg <= {sreg[DATA_LEN-2:0], evt.sda};
                if (data_end && cfg.layout_alt)
                    buf_q <= layout_alt({sreg[DATA_LEN-2:0], evt.sda});
                if (last_bit) begin
                    cnt    <= bitpos_t'(1);
                    done_q <= 1'b1;
                    if (!cfg.layout_alt || cfg.clk_delay)
                        buf_q <= layout_normal({sreg, evt.sda});
                    if (!cfg.layout_alt) begin
                        ack_q  <= ~evt.sda;
                        nack_q <= evt.sda;
                        dma_q  <= ~evt.sda & cfg.dma_on_ack;
                    end
                end else begin
                    cnt <= cnt + bitpos_t'(1);
                end
            end
        end
    end

    always_comb begin
        res.data = buf_q;
        res.done = done_q;
        res.ack  = ack_q;
        res.nack = nack_q;
        res.dma  = dma_q;
    end
endmodule

// File: rtl/i2crx_ackdrv.sv
module i2crx_ackdrv
    import i2crx_pkg::*;
(
    input  logic    ack_win,
    input  rx_cfg_t cfg,
    output logic    sda_oe,
    output logic    sda_o
);
    logic pull_low;
    assign pull_low = ack_win & ~cfg.ss_out_en & cfg.ack_out_en & ~cfg.ack_val;
    assign sda_oe   = pull_low;
    assign sda_o    = ~pull_low;
endmodule

// File: rtl/i2crx_top.sv
module i2crx_top
    import i2crx_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         scl_in,
    input  logic         sda_in,
    input  logic         cfg_layout_alt,
    input  logic         cfg_clk_delay,
    input  logic         cfg_ss_out_en,
    input  logic         cfg_ack_out_en,
    input  logic         cfg_ack_val,
    input  logic         cfg_dma_on_ack,
    output logic [8:0]   rx_buf,
    output logic         rx_done,
    output logic         ack_evt,
    output logic         nack_evt,
    output logic         dma_req,
    output logic         sda_oe,
    output logic         sda_o
);
    logic [1:0] line_s;
    line_evt_t  evt;
    rx_cfg_t    cfg;
    rx_result_t res;
    logic       ack_win;

    assign cfg = '{layout_alt: cfg_layout_alt, clk_delay: cfg_clk_delay,
                   ss_out_en: cfg_ss_out_en, ack_out_en: cfg_ack_out_en,
                   ack_val: cfg_ack_val, dma_on_ack: cfg_dma_on_ack};

    i2crx_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) u_sync (
        .clk(clk), .rst(rst), .d_async({scl_in, sda_in}), .d_sync(line_s));

    i2crx_edge u_edge (
        .clk(clk), .rst(rst), .scl_s(line_s[1]), .sda_s(line_s[0]), .evt(evt));

    i2crx_frame u_frame (
        .clk(clk), .rst(rst), .evt(evt), .cfg(cfg), .res(res), .ack_win(ack_win));

    i2crx_ackdrv u_ackdrv (
        .ack_win(ack_win), .cfg(cfg), .sda_oe(sda_oe), .sda_o(sda_o));

    assign rx_buf   = res.data;
    assign rx_done  = res.done;
    assign ack_evt  = res.ack;
    assign nack_evt = res.nack;
    assign dma_req  = res.dma;
endmodule

// File: rtl/i2crx_chk.sv
module i2crx_chk (
    input logic clk,
    input logic rst,
    input logic scl_lvl,
    input logic ack_win,
    input logic cfg_layout_alt,
    input logic cfg_dma_on_ack,
    input logic rx_done,
    input logic ack_evt,
    input logic nack_evt,
    input logic dma_req,
    input logic sda_oe,
    input logic sda_o
);
    a_r5_ack_single: assert property (@(posedge clk) disable iff (rst) ack_evt |=> !ack_evt);
    a_r5_nack_single: assert property (@(posedge clk) disable iff (rst) nack_evt |=> !nack_evt);
    a_r5_exclusive: assert property (@(posedge clk) disable iff (rst) !(ack_evt && nack_evt));
    a_r5_with_done: assert property (@(posedge clk) disable iff (rst) (ack_evt || nack_evt) |-> rx_done);
    a_r5_alt_silent: assert property (@(posedge clk) disable iff (rst)
        $past(cfg_layout_alt) |-> (!ack_evt && !nack_evt));
    a_r6_dma_needs_ack: assert property (@(posedge clk) disable iff (rst) dma_req |-> (ack_evt && $past(cfg_dma_on_ack)));
    a_r7_done_single: assert property (@(posedge clk) disable iff (rst) rx_done |=> !rx_done);
    a_r8_hold_while_high: assert property (@(posedge clk) disable iff (rst)
        (scl_lvl && $past(scl_lvl)) |-> $stable(ack_win));
    a_r8_open_drain: assert property (@(posedge clk) disable iff (rst) sda_oe |-> !sda_o);
endmodule

bind i2crx_top i2crx_chk u_chk (
    .clk(clk), .rst(rst), .scl_lvl(evt.level), .ack_win(ack_win),
    .cfg_layout_alt(cfg_layout_alt), .cfg_dma_on_ack(cfg_dma_on_ack),
    .rx_done(rx_done), .ack_evt(ack_evt), .nack_evt(nack_evt), .dma_req(dma_req),
    .sda_oe(sda_oe), .sda_o(sda_o));

// File: tb/i2crx_top_test.sv
`timescale 1ns/1ps
module i2crx_top_test;
    localparam int N    = 3;
    localparam int HALF = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl_in = 1'b1, sda_in = 1'b1;
    logic c_alt = 0, c_dly = 0, c_ss = 0, c_aen = 0, c_aval = 1, c_dma = 0;
    logic [8:0] rx_buf;
    logic rx_done, ack_evt, nack_evt, dma_req, sda_oe, sda_o;

    always #2 clk = ~clk;

    i2crx_top #(.SYNC_STAGES(N)) uut (
        .clk(clk), .rst(rst), .scl_in(scl_in), .sda_in(sda_in),
        .cfg_layout_alt(c_alt), .cfg_clk_delay(c_dly), .cfg_ss_out_en(c_ss),
        .cfg_ack_out_en(c_aen), .cfg_ack_val(c_aval), .cfg_dma_on_ack(c_dma),
        .rx_buf(rx_buf), .rx_done(rx_done), .ack_evt(ack_evt), .nack_evt(nack_evt),
        .dma_req(dma_req), .sda_oe(sda_oe), .sda_o(sda_o));

    typedef struct {
        logic [8:0] data;
        logic ack, nack, dma;
        int launch;
    } exp_t;

    exp_t q[$];
    int n_cmp = 0, n_bad = 0, cyc = 0;
    bit finished = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // monitor: pops expected items as frames complete
    always @(negedge clk) begin
        if (!rst && !finished) begin
            if (rx_done) begin
                if (q.size() == 0) check(0, "R7 unexpected rx_done", 1, 0);
                else begin
                    exp_t e;
                    e = q.pop_front();
                    check(rx_buf == e.data, "R2/R3/R4 rx_buf", rx_buf, e.data);
                    check(ack_evt == e.ack, "R5 ack_evt", ack_evt, e.ack);
                    check(nack_evt == e.nack, "R5 nack_evt", nack_evt, e.nack);
                    check(dma_req == e.dma, "R6 dma_req", dma_req, e.dma);
                    check(cyc - e.launch == N + 1, "R9 latency", cyc - e.launch, N + 1);
                end
            end else if (ack_evt || nack_evt || dma_req) begin
                check(0, "R5/R6 event without rx_done", {ack_evt, nack_evt, dma_req}, 0);
            end
        end
    end

    function automatic logic [8:0] lay_norm(input logic [8:0] s);
        return {s[0], s[8:1]};
    endfunction
    function automatic logic [8:0] lay_alt(input logic [8:0] s);
        return {s[1], 1'b0, s[8:2]};
    endfunction

    task automatic send_frame(input logic [8:0] seq, input logic alt, input logic dly,
                              input logic ss, input logic aen, input logic aval,
                              input logic dma);
        logic exp_oe;
        exp_t e;
        @(negedge clk);
        c_alt = alt; c_dly = dly; c_ss = ss; c_aen = aen; c_aval = aval; c_dma = dma;
        exp_oe = !ss && aen && !aval;
        for (int i = 8; i >= 0; i--) begin
            sda_in = seq[i];
            repeat (HALF) @(negedge clk);
            if (i == 0) begin
                if (alt) check(rx_buf == lay_alt(seq), "R3 buffer after bit 8", rx_buf, lay_alt(seq));
                e.data = (!alt || dly) ? lay_norm(seq) : lay_alt(seq);
                e.ack  = !alt && !seq[0];
                e.nack = !alt && seq[0];
                e.dma  = !alt && !seq[0] && dma;
                e.launch = cyc;
                q.push_back(e);
            end
            scl_in = 1'b1;
            repeat (3) @(negedge clk);
            if (i == 0) begin
                check(sda_oe == exp_oe, "R8 sda_oe in ninth clock", sda_oe, exp_oe);
                check(sda_o == !exp_oe, "R8 sda_o in ninth clock", sda_o, !exp_oe);
            end else begin
                check(sda_oe == 1'b0, "R8 sda_oe outside window", sda_oe, 0);
            end
            repeat (HALF - 3) @(negedge clk);
            scl_in = 1'b0;
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(rx_buf == 9'd0, "R1 rx_buf", rx_buf, 0);
        check(!rx_done && !ack_evt && !nack_evt && !dma_req, "R1 pulses",
              {rx_done, ack_evt, nack_evt, dma_req}, 0);
        check(!sda_oe && sda_o, "R1 sda", {sda_oe, sda_o}, 1);
        scl_in = 1'b0;
        repeat (HALF) @(negedge clk);
        // R2 R5 R6 R8: ACK with DMA, acknowledge driven low
        send_frame(9'b1010_0101_0, 0, 0, 0, 1, 0, 1);
        // R5 R6 R8: NACK, programmed NACK so line released
        send_frame(9'b0110_1100_1, 0, 0, 0, 1, 1, 1);
        // R6: ACK without DMA; R8 start/stop output blocks drive
        send_frame(9'b1111_0000_0, 0, 0, 1, 1, 0, 0);
        // R3: alternate layout kept
        send_frame(9'b1100_1011_1, 1, 0, 0, 0, 0, 1);
        // R4: alternate layout restored after ninth clock
        send_frame(9'b0101_1101_0, 1, 1, 0, 1, 0, 1);
        // R2 R7 boundaries: all ones, all zeros back to back
        send_frame(9'b1111_1111_1, 0, 0, 0, 1, 0, 0);
        send_frame(9'b0000_0000_0, 0, 0, 0, 1, 0, 1);
        repeat (HALF) @(negedge clk);
        check(q.size() == 0, "R7 frames completed", q.size(), 0);
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule